// File: doc/BRIEF.md
# Instruction Timing Sequencer

This block paces a simple accumulator processor through its instruction cycle. A small step counter runs freely, one step per clock. A decoder turns the count into a set of one-hot timing pulses, so that every micro-operation in the processor can be tied to a fixed clock window. The execute logic of the surrounding control unit watches these pulses. When an instruction has finished, it raises a clear request, and the next instruction begins again at the first pulse.

The sequencer also owns the fetch and decode transfers, which always fall on the first three pulses. On the first pulse the address register takes the program counter. On the second pulse the instruction register takes the memory word and the program counter advances. On the third pulse the address register takes the operand address field and the indirect flag takes the top instruction bit. Memory is read combinationally at the address register output. A stop flip-flop, set by a halt request, freezes the step, the pulses and the fetch registers until the next reset.

Top module: `instr_timing_seq`

## Requirements
- R1: While reset is active, and for the two clocks after its release, the step is 0 (only pulse 0 high), the halted flag is low, and the program counter, address register, instruction register and indirect flag are all 0.
- R2: Exactly one bit of the timing-pulse output is high in every cycle.
- R3: While not halted and not cleared, the step advances by one on each clock and wraps from 15 to 0. Pulse bit n is high when the step is n.
- R4: A clear request sampled on a clock returns the step to 0 on that clock, and it takes priority over the increment.
- R5: On a clock in step 0 that is not halted, the address register takes the program counter.
- R6: On a clock in step 1 that is not halted, the instruction register takes the memory read data, and the program counter increments modulo 4096.
- R7: On a clock in step 2 that is not halted, the address register takes instruction bits 11:0 and the indirect flag takes instruction bit 15.
- R8: A halt request sampled on a clock sets the halted flag on that clock. The flag then stays set until reset. While it is set, the step, the pulse output, the program counter, the address register, the instruction register and the indirect flag all hold, and clear requests have no effect.
- R9: On clocks in steps 3 to 15, the program counter, address register, instruction register and indirect flag hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sc_clr | input | 1 | Instruction done: restart at step 0 |
| halt_req | input | 1 | Sets the stop flip-flop |
| mem_rdata | input | 16 | Memory word read at address `ar` |
| t_pulse | output | 16 | One-hot timing pulses, bit n = step n |
| pc | output | 12 | Program counter |
| ar | output | 12 | Address register |
| ir | output | 16 | Instruction register |
| ind | output | 1 | Indirect-mode flag |
| halted | output | 1 | Stop flip-flop state |

## Verification
The bench builds the block with its default parameters: a 4-bit step, a 12-bit address and a 16-bit word. With the 4-bit step, every instruction length from 1 to 16 steps can be swept, and a halt can be placed in each of the 16 steps. With the 12-bit address, a run of a few thousand short instructions carries the program counter through its wrap from 4095 to 0. A reference model of the cycle, with an address-derived memory pattern, predicts every register after every clock.

// File: rtl/seq_pkg.sv
package seq_pkg;
  // Register-transfer strobes produced for the fetch/decode datapath
  typedef struct packed {
    logic ar_from_pc;   // step 0
    logic ir_from_mem;  // step 1
    logic pc_inc;       // step 1
    logic ar_from_ir;   // step 2 (also captures indirect bit)
  } fetch_strobe_t;
endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/seq_step_ctrl.sv
module seq_step_ctrl #(
  parameter int SC_W = 4
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            clr,
  input  logic            halt_req,
  output logic [SC_W-1:0] step,
  output logic            stop
);
  logic [SC_W-1:0] step_d;
  logic            stop_d;
  logic            step_en;

  // Stop freezes the step; clear beats increment
  always_comb begin
    step_en = !stop;
    step_d  = step;
    if (clr) step_d = '0;
    else     step_d = step + 1'b1;
    stop_d  = stop | halt_req;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      step <= '0;
      stop <= 1'b0;
    end else begin
      if (step_en) step <= step_d;
      stop <= stop_d;
    end
  end
endmodule

// File: rtl/seq_pulse_dec.sv
module seq_pulse_dec #(
  parameter int SC_W  = 4,
  localparam int NUM_T = 1 << SC_W
) (
  input  logic [SC_W-1:0]  step,
  output logic [NUM_T-1:0] pulse
);
  for (genvar gi = 0; gi < NUM_T; gi++) begin : g_dec
    assign pulse[gi] = (step == SC_W'(gi));
  end
endmodule

// File: rtl/seq_fetch_regs.sv
module seq_fetch_regs
  import seq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  fetch_strobe_t     strb,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] ar,
  output logic [WORD_W-1:0] ir,
  output logic              ind
);
  logic [ADDR_W-1:0] pc_d, ar_d;
  logic [WORD_W-1:0] ir_d;
  logic              ind_d;
  logic              pc_en, ar_en, ir_en, ind_en;

  always_comb begin
    pc_en  = strb.pc_inc;
    pc_d   = pc + 1'b1;
    ar_en  = strb.ar_from_pc | strb.ar_from_ir;
    ar_d   = strb.ar_from_pc ? pc : ir[ADDR_W-1:0];
    ir_en  = strb.ir_from_mem;
    ir_d   = mem_rdata;
    ind_en = strb.ar_from_ir;
    ind_d  = ir[WORD_W-1];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pc  <= '0;
      ar  <= '0;
      ir  <= '0;
      ind <= 1'b0;
    end else begin
      if (pc_en)  pc  <= pc_d;
      if (ar_en)  ar  <= ar_d;
      if (ir_en)  ir  <= ir_d;
      if (ind_en) ind <= ind_d;
    end
  end
endmodule

// File: rtl/instr_timing_seq.sv
module instr_timing_seq
  import seq_pkg::*;
#(
  parameter int SC_W   = 4,
  parameter int ADDR_W = 12,
  parameter int WORD_W = 16,
  localparam int NUM_T = 1 << SC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sc_clr,
  input  logic              halt_req,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [NUM_T-1:0]  t_pulse,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] ar,
  output logic [WORD_W-1:0] ir,
  output logic              ind,
  output logic              halted
);
  logic            rst_i_n;
  logic [SC_W-1:0] step;
  fetch_strobe_t   strb;

  seq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  seq_step_ctrl #(.SC_W(SC_W)) u_step (
    .clk      (clk),
    .rst_ni   (rst_i_n),
    .clr      (sc_clr),
    .halt_req (halt_req),
    .step     (step),
    .stop     (halted)
  );

  seq_pulse_dec #(.SC_W(SC_W)) u_dec (
    .step  (step),
    .pulse (t_pulse)
  );

  // Fetch and decode sit on the first three pulses
  always_comb begin
    strb.ar_from_pc  = !halted && t_pulse[0];
    strb.ir_from_mem = !halted && t_pulse[1];
    strb.pc_inc      = !halted && t_pulse[1];
    strb.ar_from_ir  = !halted && t_pulse[2];
  end

  seq_fetch_regs #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_fetch (
    .clk       (clk),
    .rst_ni    (rst_i_n),
    .strb      (strb),
    .mem_rdata (mem_rdata),
    .pc        (pc),
    .ar        (ar),
    .ir        (ir),
    .ind       (ind)
  );
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int SC_W   = 4,
  parameter int ADDR_W = 12,
  parameter int WORD_W = 16,
  localparam int NUM_T = 1 << SC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sc_clr,
  input logic              halt_req,
  input logic [WORD_W-1:0] mem_rdata,
  input logic [NUM_T-1:0]  t_pulse,
  input logic [ADDR_W-1:0] pc,
  input logic [ADDR_W-1:0] ar,
  input logic [WORD_W-1:0] ir,
  input logic              ind,
  input logic              halted
);
  always @(negedge clk)
    if (rst_n) p_onehot_r2: assert ($countones(t_pulse) == 1);

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && sc_clr) |=> t_pulse[0]);

  p_ar_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && t_pulse[0]) |=> (ar == $past(pc)));

  p_pc_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && t_pulse[1]) |=> (pc == ADDR_W'($past(pc) + 1'b1)));

  p_ir_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && t_pulse[1]) |=> (ir == $past(mem_rdata)));

  p_decode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && t_pulse[2]) |=> (ar == $past(ir[ADDR_W-1:0]) && ind == $past(ir[WORD_W-1])));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> ($stable(t_pulse) && $stable(pc) && $stable(ar) && $stable(ir) && $stable(ind)));

  p_late_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (t_pulse[0] == 1'b0 && t_pulse[1] == 1'b0 && t_pulse[2] == 1'b0)
      |=> ($stable(pc) && $stable(ar) && $stable(ir) && $stable(ind)));
endmodule

bind instr_timing_seq seq_checker #(
  .SC_W(SC_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sc_clr(sc_clr), .halt_req(halt_req),
  .mem_rdata(mem_rdata), .t_pulse(t_pulse), .pc(pc), .ar(ar), .ir(ir),
  .ind(ind), .halted(halted)
);

// File: tb/sim_instr_timing_seq.sv
`timescale 1ns/1ps
module sim_instr_timing_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sc_clr = 1'b0;
  logic        halt_req = 1'b0;
  logic [15:0] mem_rdata;
  logic [15:0] t_pulse;
  logic [11:0] pc, ar;
  logic [15:0] ir;
  logic        ind, halted;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  // Memory pattern: word derived from its own address
  function automatic logic [15:0] memf(input logic [11:0] a);
    return {a[0] ^ a[5], a[2:0], a ^ 12'h5A3};
  endfunction

  assign mem_rdata = memf(ar);

  instr_timing_seq u0 (
    .clk(clk), .rst_n(rst_n), .sc_clr(sc_clr), .halt_req(halt_req),
    .mem_rdata(mem_rdata), .t_pulse(t_pulse), .pc(pc), .ar(ar), .ir(ir),
    .ind(ind), .halted(halted)
  );

  // Reference model of the requirements
  int          m_rel;
  logic [3:0]  m_step;
  logic [11:0] m_pc, m_ar;
  logic [15:0] m_ir;
  logic        m_ind, m_s;
  string       tag_t, tag_r;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rel = 0; m_step = 0; m_pc = 0; m_ar = 0; m_ir = 0; m_ind = 0; m_s = 0;
      tag_t = "R1"; tag_r = "R1";
    end else if (m_rel < 2) begin
      m_rel++;
      tag_t = "R1"; tag_r = "R1";
    end else begin
      if (!m_s) begin
        case (m_step)
          4'd0: begin m_ar = m_pc; tag_r = "R5"; end
          4'd1: begin m_ir = memf(m_ar); m_pc = m_pc + 12'd1; tag_r = "R6"; end
          4'd2: begin m_ar = m_ir[11:0]; m_ind = m_ir[15]; tag_r = "R7"; end
          default: tag_r = "R9";
        endcase
        if (sc_clr) begin m_step = 4'd0; tag_t = "R4"; end
        else begin m_step = m_step + 4'd1; tag_t = "R3"; end
      end else begin
        tag_t = "R8"; tag_r = "R8";
      end
      m_s = m_s | halt_req;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk($countones(t_pulse) == 1, "R2", 32'(t_pulse), 32'(16'd1 << m_step));
      chk(t_pulse == (16'd1 << m_step), tag_t, 32'(t_pulse), 32'(16'd1 << m_step));
      chk(halted == m_s, m_s ? "R8" : tag_t, 32'(halted), 32'(m_s));
      chk(pc == m_pc, tag_r, 32'(pc), 32'(m_pc));
      chk(ar == m_ar, tag_r, 32'(ar), 32'(m_ar));
      chk(ir == m_ir, tag_r, 32'(ir), 32'(m_ir));
      chk(ind == m_ind, tag_r, 32'(ind), 32'(m_ind));
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sc_clr = 1'b0; halt_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);  // R1 state held through synchroniser
  endtask

  initial begin
    do_reset();
    // R3: free run across two wraps
    repeat (40) @(negedge clk);
    // R4: every instruction length 1..16, clear in the final step
    for (int len = 1; len <= 16; len++) begin
      repeat (3 * len) begin
        @(negedge clk);
        sc_clr = (m_step == 4'(len - 1));
      end
    end
    // R6: short instructions to carry PC through its wrap
    for (int k = 0; k < 4200 * 3; k++) begin
      @(negedge clk);
      sc_clr = (m_step == 4'd2);
    end
    @(negedge clk); sc_clr = 1'b0;
    // R8: halt in each step, then try clears while stopped
    for (int h = 0; h < 16; h++) begin
      do_reset();
      while (m_step != 4'(h)) @(negedge clk);
      halt_req = 1'b1;
      @(negedge clk); halt_req = 1'b0;
      for (int c = 0; c < 12; c++) begin
        @(negedge clk);
        sc_clr = c[0];
      end
      sc_clr = 1'b0;
    end
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule